// File: doc/BRIEF.md
# A-scan Background and Window Conditioning Stage

This stage sits between k-space resampling and the transform engine of a swept-source imaging pipeline. It takes a stream of real signed samples, each tagged with its position inside the current A-scan. For every sample it looks up a background constant and a complex coefficient stored for that position. It subtracts the background first. It then multiplies the result by the complex coefficient, which folds the apodization window and the dispersion phase correction into one operation. The result leaves as a complex sample stream.

Both tables are written through a plain write port that carries an address, a data word and a table select. Each table has two banks. Writes always go to the bank that is not being read. The banks swap only when an A-scan starts, which is the first accepted sample with position 0 after at least one write. A scan that is already in flight therefore never sees a mix of old and new constants. Software is expected to rewrite every entry of a table before the following scan boundary. An entry that is not rewritten keeps the value it held two generations back.

The input side and the output side both use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. The pipeline is three registers deep and stalls as a whole. `s_ready` is high exactly when the output register is empty or `m_ready` is high. While `m_valid` is high and `m_ready` is low, the output holds its value.

Top module: `ascan_precond`

## Requirements
- R1: After reset `m_valid` is low and `s_ready` is high.
- R2: The difference sample minus background is clipped to the signed 16-bit range [-32768, 32767] before any multiply.
- R3: Each output component equals floor((d*c + 8192) / 16384), where d is the clipped difference and c is the real or the imaginary coefficient read as signed Q2.14. This is round-half-toward-plus-infinity on the 14 dropped bits.
- R4: A rounded product outside [-32768, 32767] is clipped to the nearest bound, separately for `m_re` and `m_im`.
- R5: Every accepted input produces exactly one output, in order. When `m_ready` stays high, the output appears 3 cycles after the accepting edge.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_re` and `m_im` hold their values on the next cycle.
- R7: `s_ready` equals `m_ready` OR NOT `m_valid`. Whenever the output is stalled, no input is taken.
- R8: The table entry used for a sample is the one at `s_index`, whatever order the indices arrive in.
- R9: A table write never changes samples of the A-scan in progress. It takes effect from the next accepted sample with `s_index` equal to 0.
- R10: When `wr_sel` is 0, the write goes to the background table using `wr_data[15:0]`. When `wr_sel` is 1, it goes to the coefficient table with the real part in `wr_data[31:16]` and the imaginary part in `wr_data[15:0]`.
- R11: A sample with index 0 that arrives when no write has happened since the last swap keeps the current bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Stage can take an input sample |
| s_sample | input | DATA_W | Signed real input sample |
| s_index | input | IDX_W | Position of the sample inside the A-scan |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream can take the output |
| m_re | output | DATA_W | Real part of the conditioned sample |
| m_im | output | DATA_W | Imaginary part of the conditioned sample |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Table select: 0 background, 1 coefficient |
| wr_addr | input | IDX_W | Table entry to write |
| wr_data | input | 2*COEF_W | Write data, packed as in R10 |

## Verification
The hardest case to reach is a table reload that lands in the middle of an A-scan. The tail of the old scan must keep the old constants, and the next scan must pick up every new one. Reaching it means interleaving a complete table rewrite between samples of a live scan. The rewrite must leave the inactive bank fully different from the active one, so that a wrong bank choice shows in every output. The bench does this with two table generations that have distinct values at every entry. It follows that with a scan carrying no writes, which catches a swap that should not happen. Separate sweeps run under a pseudo-random `m_ready` pattern to hold outputs in stall across many cycles.

// File: rtl/ascan_precond_pkg.sv
`timescale 1ns/1ps
package ascan_precond_pkg;

  // Table targeted by the write port.
  typedef enum logic {
    TBL_BACKGROUND = 1'b0,
    TBL_WINDOW     = 1'b1
  } tbl_sel_e;

  // Register stages between the input handshake and the output register.
  localparam int PIPE_STAGES = 3;

endpackage

// File: rtl/ascan_bank_ctrl.sv
`timescale 1ns/1ps
// Tracks which bank is live and flips it on the first sample of an A-scan
// once the shadow bank has received writes.
module ascan_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_any,
  input  logic accept,
  input  logic first_idx,
  output logic act_bank,
  output logic rd_bank
);

  logic pending;
  logic swap;

  assign swap    = accept && first_idx && pending;
  // The sample that triggers the swap already reads from the new bank.
  assign rd_bank = act_bank ^ swap;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_bank <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (swap) act_bank <= ~act_bank;
      pending <= swap ? 1'b0 : (pending | wr_any);
    end
  end

endmodule

// File: rtl/ascan_dual_table.sv
`timescale 1ns/1ps
// Two-bank table: one bank is written, the other is read, with a
// registered read port.
module ascan_dual_table #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic rd_bank_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
      if (rd_en && (rd_bank == 1'(b))) q <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_bank_q <= rd_bank;
  end

  assign rd_data = rd_bank_q ? g_bank[1].q : g_bank[0].q;

endmodule

// File: rtl/ascan_sat_sub.sv
`timescale 1ns/1ps
// Registered a - b, clipped to the signed W-bit range.
module ascan_sat_sub #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                en,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);

  logic signed [W:0]   diff;
  logic signed [W-1:0] clip;

  always_comb begin
    diff = {a[W-1], a} - {b[W-1], b};
    if (diff[W] == diff[W-1])
      clip = diff[W-1:0];
    else if (diff[W])
      clip = {1'b1, {(W-1){1'b0}}};
    else
      clip = {1'b0, {(W-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (en) y <= clip;
  end

endmodule

// File: rtl/ascan_cplx_scale.sv
`timescale 1ns/1ps
// Real sample times a complex fixed-point coefficient. Each lane rounds
// half-up on the dropped fraction bits and clips to OW bits.
module ascan_cplx_scale #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 14,
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic signed [DW-1:0] d,
  input  logic signed [CW-1:0] c_re,
  input  logic signed [CW-1:0] c_im,
  output logic signed [OW-1:0] re,
  output logic signed [OW-1:0] im
);

  localparam int PW = DW + CW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] HALF = {{(SW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [CW-1:0] coef;
    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] shr;
    logic signed [OW-1:0] clip;
    logic signed [OW-1:0] q;

    assign coef = (k == 0) ? c_re : c_im;

    always_comb begin
      prod = d * coef;
      sum  = {prod[PW-1], prod} + HALF;
      shr  = sum >>> FW;
      if ((&shr[SW-1:OW-1]) || !(|shr[SW-1:OW-1]))
        clip = shr[OW-1:0];
      else if (shr[SW-1])
        clip = {1'b1, {(OW-1){1'b0}}};
      else
        clip = {1'b0, {(OW-1){1'b1}}};
    end

    always_ff @(posedge clk) begin
      if (en) q <= clip;
    end
  end

  assign re = g_lane[0].q;
  assign im = g_lane[1].q;

endmodule

// File: rtl/ascan_precond.sv
`timescale 1ns/1ps
// Pre-transform conditioning: per-index background removal, then one
// complex multiply that applies window and dispersion phase together.
module ascan_precond
  import ascan_precond_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int DEPTH   = 1024,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int WR_W   = 2 * COEF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_sample,
  input  logic [IDX_W-1:0]  s_index,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_re,
  output logic [DATA_W-1:0] m_im,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WR_W-1:0]   wr_data
);

  logic        advance;
  logic        accept;
  logic        first_idx;
  logic        act_bank;
  logic        rd_bank;
  tbl_sel_e    sel;
  logic        bg_we;
  logic        cf_we;

  logic [DATA_W-1:0] bg_q;
  logic [WR_W-1:0]   coef_q;

  logic              v1, v2;
  logic [DATA_W-1:0] samp1;
  logic [DATA_W-1:0] diff2;
  logic [WR_W-1:0]   coef2;

  // The whole pipe moves together; it stops only when the output is held.
  assign advance   = !m_valid || m_ready;
  assign s_ready   = advance;
  assign accept    = s_valid && advance;
  assign first_idx = (s_index == '0);

  assign sel   = tbl_sel_e'(wr_sel);
  assign bg_we = wr_en && (sel == TBL_BACKGROUND);
  assign cf_we = wr_en && (sel == TBL_WINDOW);

  ascan_bank_ctrl u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_any    (wr_en),
    .accept    (accept),
    .first_idx (first_idx),
    .act_bank  (act_bank),
    .rd_bank   (rd_bank)
  );

  ascan_dual_table #(.W(DATA_W), .DEPTH(DEPTH)) u_bg_tbl (
    .clk     (clk),
    .wr_en   (bg_we),
    .wr_bank (~act_bank),
    .wr_addr (wr_addr),
    .wr_data (wr_data[DATA_W-1:0]),
    .rd_en   (advance),
    .rd_bank (rd_bank),
    .rd_addr (s_index),
    .rd_data (bg_q)
  );

  ascan_dual_table #(.W(WR_W), .DEPTH(DEPTH)) u_cf_tbl (
    .clk     (clk),
    .wr_en   (cf_we),
    .wr_bank (~act_bank),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (advance),
    .rd_bank (rd_bank),
    .rd_addr (s_index),
    .rd_data (coef_q)
  );

  // Stage 1: sample captured alongside the table reads.
  always_ff @(posedge clk) begin
    if (advance) samp1 <= s_sample;
  end

  // Stage 2: clipped subtraction; the coefficient rides along.
  ascan_sat_sub #(.W(DATA_W)) u_sub (
    .clk (clk),
    .en  (advance),
    .a   (samp1),
    .b   (bg_q),
    .y   (diff2)
  );

  always_ff @(posedge clk) begin
    if (advance) coef2 <= coef_q;
  end

  // Stage 3: complex scale into the output register.
  ascan_cplx_scale #(
    .DW (DATA_W),
    .CW (COEF_W),
    .FW (FRAC_W),
    .OW (DATA_W)
  ) u_scale (
    .clk  (clk),
    .en   (advance),
    .d    (diff2),
    .c_re (coef2[WR_W-1:COEF_W]),
    .c_im (coef2[COEF_W-1:0]),
    .re   (m_re),
    .im   (m_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      m_valid <= 1'b0;
    end else if (advance) begin
      v1      <= s_valid;
      v2      <= v1;
      m_valid <= v2;
    end
  end

endmodule

// File: rtl/ascan_precond_chk.sv
`timescale 1ns/1ps
module ascan_precond_chk #(
  parameter int W  = 16,
  parameter int IW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic [IW-1:0] s_index,
  input logic          m_valid,
  input logic          m_ready,
  input logic [W-1:0]  m_re,
  input logic [W-1:0]  m_im,
  input logic          act_bank
);

  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(posedge clk) begin
    if (!rst && rst_q) begin
      idle_after_reset_chk: assert (!m_valid);
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_re) && $stable(m_im)));

  // R7
  no_take_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  // R5
  three_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) ##1 s_ready ##1 s_ready |=> m_valid);

  // R9
  bank_flip_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_bank) |-> $past(s_valid && s_ready && (s_index == '0)));

endmodule

bind ascan_precond ascan_precond_chk #(.W(DATA_W), .IW(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_index  (s_index),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_re     (m_re),
  .m_im     (m_im),
  .act_bank (act_bank)
);

// File: tb/tb_ascan_precond.sv
`timescale 1ns/1ps
module tb_ascan_precond;

  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int FW    = 14;
  localparam int DEPTH = 8;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          s_valid;
  logic          s_ready;
  logic [DW-1:0] s_sample;
  logic [IW-1:0] s_index;
  logic          m_valid;
  logic          m_ready;
  logic [DW-1:0] m_re;
  logic [DW-1:0] m_im;
  logic          wr_en;
  logic          wr_sel;
  logic [IW-1:0] wr_addr;
  logic [2*CW-1:0] wr_data;

  always #2 clk = ~clk;

  ascan_precond #(.DATA_W(DW), .COEF_W(CW), .FRAC_W(FW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .s_index(s_index), .m_valid(m_valid),
    .m_ready(m_ready), .m_re(m_re), .m_im(m_im), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Model of the two banks per R9/R10/R11.
  int mbg [2][DEPTH];
  int mcr [2][DEPTH];
  int mci [2][DEPTH];
  int mact = 0;
  bit mpend = 0;

  int    q_re [$];
  int    q_im [$];
  int    q_cy [$];
  string q_tag [$];

  string cur_tag = "R2";
  bit lat_mode = 0;
  bit bp_mode = 0;
  bit last_acc = 0;
  bit stall_prev = 0;
  logic [DW-1:0] pre_re, pre_im;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int qmul(int d, int c);
    return sat16((d * c + 8192) >>> 14);
  endfunction

  task automatic fail(string r, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
  endtask

  task automatic tick();
    int er, ei, ec, d, bk;
    string tg;
    #1;
    // R7
    checks++;
    if (s_ready !== (m_ready || !m_valid)) fail("R7", "s_ready", int'(s_ready), int'(m_ready || !m_valid));
    // R6
    if (stall_prev) begin
      checks++;
      if (!(m_valid === 1'b1 && m_re === pre_re && m_im === pre_im))
        fail("R6", "held output re", int'($signed(m_re)), int'($signed(pre_re)));
    end
    if (m_valid && m_ready) begin
      if (q_re.size() == 0) begin
        checks++;
        fail("R5", "unexpected output count", 1, 0);
      end else begin
        er = q_re.pop_front(); ei = q_im.pop_front();
        ec = q_cy.pop_front(); tg = q_tag.pop_front();
        checks++;
        if (int'($signed(m_re)) != er) fail(tg, "m_re", int'($signed(m_re)), er);
        checks++;
        if (int'($signed(m_im)) != ei) fail(tg, "m_im", int'($signed(m_im)), ei);
        if (lat_mode) begin
          checks++;
          if (cyc - ec != 3) fail("R5", "latency", cyc - ec, 3);
        end
      end
    end
    last_acc = 0;
    if (s_valid && s_ready && !rst) begin
      last_acc = 1;
      if (s_index == '0 && mpend) begin
        mact = 1 - mact;
        mpend = 0;
      end
      d = sat16(int'($signed(s_sample)) - mbg[mact][s_index]);
      q_re.push_back(qmul(d, mcr[mact][s_index]));
      q_im.push_back(qmul(d, mci[mact][s_index]));
      q_cy.push_back(cyc);
      q_tag.push_back(cur_tag);
    end
    if (wr_en && !rst) begin
      bk = 1 - mact;
      if (wr_sel == 1'b0) mbg[bk][wr_addr] = int'($signed(wr_data[15:0]));
      else begin
        mcr[bk][wr_addr] = int'($signed(wr_data[31:16]));
        mci[bk][wr_addr] = int'($signed(wr_data[15:0]));
      end
      mpend = 1;
    end
    stall_prev = m_valid && !m_ready && !rst;
    pre_re = m_re;
    pre_im = m_im;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  endtask

  task automatic write_word(bit sel, int addr, logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_addr = IW'(addr); wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic int gen_bg(int g, int i);
    if (g == 0) begin
      if (i == 6) return -32768;
      if (i == 7) return 32767;
      return i * 1500 - 4000;
    end
    return 2000 - i * 700;
  endfunction

  function automatic int gen_cr(int g, int i);
    if (g == 0) begin
      if (i == 6) return -32768;
      if (i == 7) return 8192;
      return (i % 2 == 0) ? 16384 : -12000;
    end
    return 20000 - i * 3000;
  endfunction

  function automatic int gen_ci(int g, int i);
    if (g == 0) begin
      if (i == 6) return 32767;
      if (i == 7) return -8192;
      return i * 3000 - 9000;
    end
    return -5000 + i * 1111;
  endfunction

  // R10: background in [15:0]; coefficient real in [31:16], imaginary in [15:0].
  task automatic load_gen(int g);
    for (int i = 0; i < DEPTH; i++) begin
      write_word(1'b0, i, {16'h0000, 16'(gen_bg(g, i))});
      write_word(1'b1, i, {16'(gen_cr(g, i)), 16'(gen_ci(g, i))});
    end
  endtask

  task automatic send(int samp, int idx);
    bit done = 0;
    s_valid = 1'b1; s_sample = DW'(samp); s_index = IW'(idx);
    for (int g = 0; g < 100 && !done; g++) begin
      tick();
      done = last_acc;
    end
    s_valid = 1'b0;
    if (!done) begin
      checks++;
      fail("R7", "input never accepted", 0, 1);
    end
  endtask

  task automatic drain();
    bp_mode = 0;
    m_ready = 1'b1;
    for (int g = 0; g < 60 && q_re.size() > 0; g++) tick();
    tick(); tick(); tick();
  endtask

  initial begin
    rst = 1'b1; s_valid = 1'b0; s_sample = '0; s_index = '0;
    m_ready = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    checks++;
    if (m_valid !== 1'b0) fail("R1", "m_valid after reset", int'(m_valid), 0);
    checks++;
    if (s_ready !== 1'b1) fail("R1", "s_ready after reset", int'(s_ready), 1);
    @(negedge clk);

    load_gen(0);

    // Ramp scan with fixed latency, saturation and half-way rounding.
    lat_mode = 1;
    cur_tag = "R2";
    for (int i = 0; i < 6; i++) send(i * 5000 - 12000, i);
    cur_tag = "R4";
    send(32767, 6);
    cur_tag = "R3";
    send(32766, 7);
    drain();
    cur_tag = "R2";
    send(0, 0);
    send(-32768, 7);
    drain();
    lat_mode = 0;

    // Sweeps over sample values, alternate scans under back-pressure.
    cur_tag = "R3";
    for (int k = 0; k < 16; k++) begin
      bp_mode = k[0];
      for (int i = 0; i < DEPTH; i++)
        send(((k * 7919 + i * 4093 + 12345) % 65536) - 32768, i);
    end
    drain();

    // R8: indices in scrambled order after the start.
    cur_tag = "R8";
    send(1111, 0); send(-2222, 5); send(3333, 2); send(-4444, 7);
    send(5555, 1); send(-6666, 3); send(7777, 6); send(-8888, 4);
    drain();

    // R9: reload in the middle of a scan.
    cur_tag = "R9";
    for (int i = 0; i < 4; i++) send(i * 3000 - 7000, i);
    load_gen(1);
    for (int i = 4; i < DEPTH; i++) send(i * 3000 - 7000, i);
    drain();

    // R10: new generation becomes visible at the next start.
    cur_tag = "R10";
    for (int i = 0; i < DEPTH; i++) send(i * 4100 - 15000, i);
    drain();

    // R11: start without writes keeps the live bank.
    cur_tag = "R11";
    bp_mode = 1;
    for (int i = 0; i < DEPTH; i++) send(-i * 3900 + 14000, i);
    drain();

    // R5: one output for each accepted input.
    checks++;
    if (q_re.size() != 0) fail("R5", "outputs missing", 0, q_re.size());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule